// File: doc/BRIEF.md
# Chunked Reserve/Commit Ring Queue

This block is a bounded circular queue whose storage is a fixed array of equally sized chunks. Every operation works on whole chunks. A producer either pushes one chunk in a single step, or reserves a run of contiguous chunks, fills them in place through a write port, and later commits some or all of them. The consumer side has the same reserve/commit window interface. It reserves committed chunks, reads them in place through a read port, and commits them once it has consumed them.

Consumed chunks are not freed at once. A consumer commit sets a done flag on each chunk it covers. A reclaim pointer then walks forward one chunk per cycle over the unbroken run of done chunks. It clears each flag as it passes and returns the chunk to the free pool. All pointers carry one wrap bit, so a full ring and an empty ring are told apart. The chunk count must be a power of two, at least 2. A requester whose reserve cannot be granted sees its ready low and simply holds its request. Committing more chunks than are reserved sets a sticky error flag and changes nothing else.

Top module: `chunk_ring`

## Requirements
- R1: After reset the ring is empty and err is 0. A producer reserve of NCHUNK chunks is ready, and a push is ready. A consumer reserve of 1 is not ready. Both window ids read 0.
- R2: A producer reserve of n chunks is ready only when n is at most the free count. The free count is NCHUNK minus the chunks held between the reclaim pointer and the producer reserve pointer. When not ready, nothing is allocated, partly or otherwise.
- R3: The cycle after a reserve is granted, that side's window shows three things. The base is the ring index (0..NCHUNK-1) of the first reserved chunk. The count is n. The id is the previous id plus 1, modulo 2^ID_W. Successive windows are contiguous modulo NCHUNK.
- R4: A producer commit of n moves the n oldest producer-reserved chunks to the consumer. A consumer reserve of k is ready only when at least k committed chunks are not yet reserved by the consumer.
- R5: A push writes prod_push_data into the next chunk and commits it in the same cycle. It is ready only when at least one chunk is free and no producer-reserved chunk is still uncommitted.
- R6: A consumer commit of n marks its n oldest reserved chunks done. The reclaim pointer frees at most one done chunk per cycle, in ring order. A chunk consumed at clock edge E is therefore free only from edge E+1 onward.
- R7: A commit of more chunks than its side has reserved sets err, which stays 1 until reset. That commit changes no pointer and no flag.
- R8: Ring indices wrap modulo NCHUNK. With all NCHUNK chunks committed and none consumed, a producer reserve of 1 is not ready. A consumer reserve of NCHUNK is ready.
- R9: On the producer side, a commit request blocks push and reserve in the same cycle, and a push request blocks a reserve. On the consumer side, a commit request blocks a reserve.
- R10: prod_wr_en writes prod_wr_data to chunk prod_wr_idx, unless a push is accepted in that cycle, in which case only the push writes. cons_rd_data shows chunk cons_rd_idx combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prod_push_valid | input | 1 | Push one chunk |
| prod_push_data | input | CHUNK_BYTES*8 | Push payload |
| prod_push_ready | output | 1 | Push accepted this cycle |
| prod_rsv_valid | input | 1 | Producer reserve request |
| prod_rsv_num | input | log2(NCHUNK)+1 | Chunks asked for |
| prod_rsv_ready | output | 1 | Producer reserve granted |
| prod_cmt_valid | input | 1 | Producer commit |
| prod_cmt_num | input | log2(NCHUNK)+1 | Chunks committed |
| prod_wr_en | input | 1 | In-place chunk write |
| prod_wr_idx | input | log2(NCHUNK) | Chunk written |
| prod_wr_data | input | CHUNK_BYTES*8 | Write payload |
| prod_win_base | output | log2(NCHUNK) | Producer window first chunk |
| prod_win_num | output | log2(NCHUNK)+1 | Producer window size |
| prod_win_id | output | ID_W | Producer window id |
| cons_rsv_valid | input | 1 | Consumer reserve request |
| cons_rsv_num | input | log2(NCHUNK)+1 | Chunks asked for |
| cons_rsv_ready | output | 1 | Consumer reserve granted |
| cons_cmt_valid | input | 1 | Consumer commit |
| cons_cmt_num | input | log2(NCHUNK)+1 | Chunks consumed |
| cons_rd_idx | input | log2(NCHUNK) | Chunk read |
| cons_rd_data | output | CHUNK_BYTES*8 | Read payload |
| cons_win_base | output | log2(NCHUNK) | Consumer window first chunk |
| cons_win_num | output | log2(NCHUNK)+1 | Consumer window size |
| cons_win_id | output | ID_W | Consumer window id |
| err | output | 1 | Sticky over-commit error |

## Verification
Several properties are checked on every cycle. Occupancy never exceeds the chunk count, and the committed head never passes the reclaim span. The reclaim pointer moves at most one chunk per edge. A refused reserve leaves the allocation pointer alone, and a push advances both tails by one. Window base and id follow the grant, and an over-commit leaves the tail unchanged with err staying set. Only the bench scenarios can show the rest. These are the exact ready decisions under mixed traffic, the data returned in place after writes and pushes, the full-ring boundary, the lag between consumption and reuse, and the request priorities.

// File: rtl/chunk_ring.sv
module chunk_ring #(
  parameter int NCHUNK      = 8,
  parameter int CHUNK_BYTES = 4,
  parameter int ID_W        = 4,
  localparam int LW = $clog2(NCHUNK),
  localparam int IW = LW + 1,
  localparam int DW = CHUNK_BYTES * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prod_push_valid,
  input  logic [DW-1:0] prod_push_data,
  output logic          prod_push_ready,
  input  logic          prod_rsv_valid,
  input  logic [IW-1:0] prod_rsv_num,
  output logic          prod_rsv_ready,
  input  logic          prod_cmt_valid,
  input  logic [IW-1:0] prod_cmt_num,
  input  logic          prod_wr_en,
  input  logic [LW-1:0] prod_wr_idx,
  input  logic [DW-1:0] prod_wr_data,
  output logic [LW-1:0] prod_win_base,
  output logic [IW-1:0] prod_win_num,
  output logic [ID_W-1:0] prod_win_id,
  input  logic          cons_rsv_valid,
  input  logic [IW-1:0] cons_rsv_num,
  output logic          cons_rsv_ready,
  input  logic          cons_cmt_valid,
  input  logic [IW-1:0] cons_cmt_num,
  input  logic [LW-1:0] cons_rd_idx,
  output logic [DW-1:0] cons_rd_data,
  output logic [LW-1:0] cons_win_base,
  output logic [IW-1:0] cons_win_num,
  output logic [ID_W-1:0] cons_win_id,
  output logic          err
);
  localparam logic [IW-1:0] NFULL = IW'(NCHUNK);

  logic [IW-1:0] ta, tc, ha, hc, rc;
  logic [NCHUNK-1:0] done, done_set, done_clr;
  logic [DW-1:0] mem [NCHUNK];

  wire [IW-1:0] used    = ta - rc;
  wire [IW-1:0] free    = NFULL - used;
  wire [IW-1:0] p_open  = ta - tc;
  wire [IW-1:0] c_avail = tc - ha;
  wire [IW-1:0] c_open  = ha - hc;

  assign prod_push_ready = !prod_cmt_valid && (p_open == '0) && (free != '0);
  assign prod_rsv_ready  = !prod_cmt_valid && !prod_push_valid && (free >= prod_rsv_num);
  assign cons_rsv_ready  = !cons_cmt_valid && (c_avail >= cons_rsv_num);

  wire push_go = prod_push_valid && prod_push_ready;
  wire prsv_go = prod_rsv_valid && prod_rsv_ready;
  wire crsv_go = cons_rsv_valid && cons_rsv_ready;
  wire pcmt_ok = prod_cmt_valid && (prod_cmt_num <= p_open);
  wire ccmt_ok = cons_cmt_valid && (cons_cmt_num <= c_open);
  wire bad_cmt = (prod_cmt_valid && !pcmt_ok) || (cons_cmt_valid && !ccmt_ok);
  wire rc_go   = done[rc[LW-1:0]];

  always_comb begin
    logic [LW-1:0] off;
    done_clr = '0;
    done_clr[rc[LW-1:0]] = rc_go;
    for (int i = 0; i < NCHUNK; i++) begin
      off = LW'(i) - hc[LW-1:0];
      done_set[i] = ccmt_ok && ({1'b0, off} < cons_cmt_num);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ta <= '0; tc <= '0; ha <= '0; hc <= '0; rc <= '0;
      done <= '0;
      err  <= 1'b0;
      prod_win_base <= '0; prod_win_num <= '0; prod_win_id <= '0;
      cons_win_base <= '0; cons_win_num <= '0; cons_win_id <= '0;
    end else begin
      ta <= ta + (push_go ? IW'(1) : (prsv_go ? prod_rsv_num : '0));
      tc <= tc + (push_go ? IW'(1) : (pcmt_ok ? prod_cmt_num : '0));
      ha <= ha + (crsv_go ? cons_rsv_num : '0);
      hc <= hc + (ccmt_ok ? cons_cmt_num : '0);
      rc <= rc + IW'(rc_go);
      done <= (done & ~done_clr) | done_set;
      if (bad_cmt) err <= 1'b1;
      if (prsv_go) begin
        prod_win_base <= ta[LW-1:0];
        prod_win_num  <= prod_rsv_num;
        prod_win_id   <= prod_win_id + 1'b1;
      end
      if (crsv_go) begin
        cons_win_base <= ha[LW-1:0];
        cons_win_num  <= cons_rsv_num;
        cons_win_id   <= cons_win_id + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push_go) mem[ta[LW-1:0]] <= prod_push_data;
    else if (prod_wr_en) mem[prod_wr_idx] <= prod_wr_data;
  end

  assign cons_rd_data = mem[cons_rd_idx];

  // R2
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ta - rc) <= NFULL);
  // R2
  rsv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_rsv_valid && !prod_rsv_ready && !prod_push_valid) |=> (ta == $past(ta)));
  // R3
  win_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prsv_go |=> (prod_win_base == $past(ta[LW-1:0])) && (prod_win_id == $past(prod_win_id) + 1'b1));
  // R5
  push_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_go |=> (tc == $past(tc) + 1'b1) && (ta == $past(ta) + 1'b1));
  // R6
  reclaim_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rc - $past(rc)) <= IW'(1)));
  // R6
  ptr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((hc - rc) <= (ha - rc)) && ((ha - rc) <= (tc - rc)) && ((tc - rc) <= (ta - rc)));
  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  // R7
  overcommit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_cmt_valid && (prod_cmt_num > (ta - tc))) |=> (tc == $past(tc)) && err);
endmodule

// File: tb/chunk_ring_bench.sv
module chunk_ring_bench;
  localparam int N = 8;
  localparam int LW = 3;
  localparam int IW = 4;
  localparam int DW = 32;

  logic clk = 0, rst_n = 0;
  logic pp_v = 0; logic [DW-1:0] pp_d = 0; logic pp_r;
  logic pr_v = 0; logic [IW-1:0] pr_n = 0; logic pr_r;
  logic pc_v = 0; logic [IW-1:0] pc_n = 0;
  logic pw_e = 0; logic [LW-1:0] pw_i = 0; logic [DW-1:0] pw_d = 0;
  logic [LW-1:0] pwb; logic [IW-1:0] pwn; logic [3:0] pwid;
  logic cr_v = 0; logic [IW-1:0] cr_n = 0; logic cr_r;
  logic cc_v = 0; logic [IW-1:0] cc_n = 0;
  logic [LW-1:0] rd_i = 0; logic [DW-1:0] rd_d;
  logic [LW-1:0] cwb; logic [IW-1:0] cwn; logic [3:0] cwid;
  logic err;

  always #5 clk = ~clk;

  chunk_ring u_chunk_ring (
    .clk(clk), .rst_n(rst_n),
    .prod_push_valid(pp_v), .prod_push_data(pp_d), .prod_push_ready(pp_r),
    .prod_rsv_valid(pr_v), .prod_rsv_num(pr_n), .prod_rsv_ready(pr_r),
    .prod_cmt_valid(pc_v), .prod_cmt_num(pc_n),
    .prod_wr_en(pw_e), .prod_wr_idx(pw_i), .prod_wr_data(pw_d),
    .prod_win_base(pwb), .prod_win_num(pwn), .prod_win_id(pwid),
    .cons_rsv_valid(cr_v), .cons_rsv_num(cr_n), .cons_rsv_ready(cr_r),
    .cons_cmt_valid(cc_v), .cons_cmt_num(cc_n),
    .cons_rd_idx(rd_i), .cons_rd_data(rd_d),
    .cons_win_base(cwb), .cons_win_num(cwn), .cons_win_id(cwid),
    .err(err));

  int tests = 0, fails = 0;
  bit finished = 0;
  int ta, tc, ha, hc, rc, pid, cid, m_pwb, m_pwn, m_cwb, m_cwn;
  bit m_err;
  bit done_m [N];
  bit memv [N];
  logic [DW-1:0] mem_m [N];

  task automatic chk(string tag, longint act, longint exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_push();
    return !pc_v && (ta == tc) && (ta - rc < N);
  endfunction
  function automatic bit exp_prsv();
    return !pc_v && !pp_v && (N - (ta - rc) >= int'(pr_n));
  endfunction
  function automatic bit exp_crsv();
    return !cc_v && (tc - ha >= int'(cr_n));
  endfunction

  task automatic idle();
    pp_v = 0; pr_v = 0; pc_v = 0; pw_e = 0; cr_v = 0; cc_v = 0;
    pr_n = 0; pc_n = 0; cr_n = 0; cc_n = 0;
  endtask

  task automatic look();
    #1;
    chk("R5 push_ready", pp_r, exp_push());
    chk("R2 prod_rsv_ready", pr_r, exp_prsv());
    chk("R4 cons_rsv_ready", cr_r, exp_crsv());
    chk("R3 prod_win_base", pwb, m_pwb);
    chk("R3 prod_win_num", pwn, m_pwn);
    chk("R3 prod_win_id", pwid, pid);
    chk("R3 cons_win_base", cwb, m_cwb);
    chk("R3 cons_win_num", cwn, m_cwn);
    chk("R3 cons_win_id", cwid, cid);
    chk("R7 err", err, m_err);
    if (memv[rd_i]) chk("R10 rd_data", rd_d, mem_m[rd_i]);
  endtask

  task automatic adv();
    bit push_go, prsv_go, crsv_go;
    push_go = pp_v && exp_push();
    prsv_go = pr_v && exp_prsv();
    crsv_go = cr_v && exp_crsv();
    if (done_m[rc % N]) begin done_m[rc % N] = 0; rc++; end
    if (cc_v) begin
      if (int'(cc_n) <= ha - hc) begin
        for (int j = 0; j < int'(cc_n); j++) done_m[(hc + j) % N] = 1;
        hc += int'(cc_n);
      end else m_err = 1;
    end
    if (pc_v) begin
      if (int'(pc_n) <= ta - tc) tc += int'(pc_n);
      else m_err = 1;
    end
    if (push_go) begin
      mem_m[ta % N] = pp_d; memv[ta % N] = 1; ta++; tc++;
    end else if (pw_e) begin
      mem_m[pw_i] = pw_d; memv[pw_i] = 1;
    end
    if (prsv_go) begin
      m_pwb = ta % N; m_pwn = int'(pr_n); pid = (pid + 1) % 16; ta += int'(pr_n);
    end
    if (crsv_go) begin
      m_cwb = ha % N; m_cwn = int'(cr_n); cid = (cid + 1) % 16; ha += int'(cr_n);
    end
  endtask

  task automatic step();
    look();
    adv();
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    ta = 0; tc = 0; ha = 0; hc = 0; rc = 0; pid = 0; cid = 0;
    m_pwb = 0; m_pwn = 0; m_cwb = 0; m_cwn = 0; m_err = 0;
    for (int i = 0; i < N; i++) begin done_m[i] = 0; memv[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    idle(); pr_n = IW'(N); cr_n = 1;
    #1;
    chk("R1 prod_rsv_ready", pr_r, 1);
    chk("R1 cons_rsv_ready", cr_r, 0);
    chk("R1 push_ready", pp_r, 1);
    chk("R1 err", err, 0);
    chk("R1 win ids", {pwid, cwid}, 0);
    step();
    // fill whole ring by reservation, write in place
    idle(); pr_v = 1; pr_n = IW'(N); step();
    for (int i = 0; i < N; i++) begin
      idle(); pw_e = 1; pw_i = LW'(i); pw_d = 32'hA000 + i; pr_n = 1;
      look();
      if (i == 0) begin
        chk("R3 window base", pwb, 0);
        chk("R3 window num", pwn, N);
        chk("R3 window id", pwid, 1);
        chk("R8 full reserve refused", pr_r, 0);
      end
      adv(); @(negedge clk);
    end
    idle(); pc_v = 1; pc_n = IW'(N); step();
    idle(); cr_v = 1; cr_n = IW'(N); rd_i = 5;
    look();
    chk("R8 full ring consumer ready", cr_r, 1);
    chk("R10 read in place", rd_d, 32'hA005);
    adv(); @(negedge clk);
    idle(); cc_v = 1; cc_n = IW'(N); step();
    idle(); pr_n = 1;
    look();
    chk("R6 reclaim lag", pr_r, 0);
    adv(); @(negedge clk);
    for (int i = 0; i < N; i++) begin idle(); step(); end
    idle(); pr_n = IW'(N);
    look();
    chk("R6 all reclaimed", pr_r, 1);
    adv(); @(negedge clk);
    // R9 priorities
    idle(); pp_v = 1; pp_d = 32'h55; pr_v = 1; pr_n = 1;
    look();
    chk("R9 push beats reserve", {pp_r, pr_r}, 2'b10);
    adv(); @(negedge clk);
    idle(); pc_v = 1; pc_n = 0; pp_v = 1; cc_v = 1; cc_n = 0; cr_n = 0;
    look();
    chk("R9 commit blocks push", pp_r, 0);
    chk("R9 commit blocks cons reserve", cr_r, 0);
    adv(); @(negedge clk);
    // random traffic
    for (int k = 0; k < 4000; k++) begin
      int r;
      idle();
      r = $urandom_range(0, 9);
      if (r < 3) begin pc_v = 1; pc_n = IW'($urandom_range(0, ta - tc)); end
      else if (r < 6) begin pp_v = 1; pp_d = $urandom(); end
      else begin pr_v = 1; pr_n = IW'($urandom_range(0, 4)); end
      if ($urandom_range(0, 1) == 1) pr_v = 1;
      if ($urandom_range(0, 2) == 0) begin
        pw_e = 1; pw_i = LW'($urandom_range(0, N - 1)); pw_d = $urandom();
      end
      r = $urandom_range(0, 9);
      if (r < 4) begin cc_v = 1; cc_n = IW'($urandom_range(0, ha - hc)); end
      else begin cr_v = 1; cr_n = IW'($urandom_range(0, 4)); end
      rd_i = LW'($urandom_range(0, N - 1));
      step();
    end
    // R7 over-commit
    idle(); pc_v = 1; pc_n = IW'(ta - tc + 1); step();
    idle(); cr_n = 1;
    look();
    chk("R7 err set", err, 1);
    adv(); @(negedge clk);
    idle(); cc_v = 1; cc_n = IW'(ha - hc + 1); step();
    idle(); step();
    idle(); look();
    chk("R7 err stays", err, 1);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule